// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a synchronous host and one external asynchronous static RAM of 128K words by 8 bits. The host issues single-word requests over a valid/ready port: a write carries an address and a byte, a read carries an address and gets its byte back with a one-cycle response pulse. The block turns each request into the pin-level sequence the memory expects. It drives active-low chip select, write strobe and output enable, a 17-bit address, and a data bus split into an outgoing byte, an incoming byte and a driver enable.

All memory timing is expressed as whole clock cycles. Each interval is a parameter, rounded up from the nanosecond figure of the chosen speed grade at the chosen clock period. Writes are strobe-controlled with output enable held inactive throughout, which permits the shorter pulse. The sequencer leaves the bus undriven by the controller while the memory may still be driving it, and keeps the memory's outputs off while the controller drives, so the two never overlap.

The sequencer is a single state machine with seven states. `ST_IDLE` is ready and accepts a request. `ST_RD_ACCESS` asserts select and output enable for the access time. `ST_RD_RELEASE` lifts both while the memory lets go of the bus. `ST_WR_ADDR` presents the address with select low. `ST_WR_GAP` pulls the write strobe low with drivers still off. `ST_WR_DRIVE` drives the byte with the strobe low. `ST_WR_HOLD` lifts the strobe while still driving.

The transitions are as follows. `ST_IDLE` goes to `ST_RD_ACCESS` or `ST_WR_ADDR` on an accepted read or write. `ST_RD_ACCESS` goes to `ST_RD_RELEASE` when its timer expires, capturing the data. `ST_RD_RELEASE` goes to `ST_IDLE` when its timer expires. `ST_WR_ADDR` always goes to `ST_WR_GAP` after one cycle. `ST_WR_GAP` goes to `ST_WR_DRIVE` when its timer expires. `ST_WR_DRIVE` goes to `ST_WR_HOLD` when its timer expires. `ST_WR_HOLD` always goes to `ST_IDLE` after one cycle.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: req_ready is 1 only while the sequencer is idle, with all three strobes high; a request is taken on a clock edge where req_valid and req_ready are both 1.
- R3: A read holds mem_ce_n and mem_oe_n at 0 and mem_we_n at 1 for exactly RD_ACC_CYC consecutive cycles, beginning in the cycle after acceptance.
- R4: rsp_valid is 1 for exactly one cycle, the cycle after the last access cycle, and rsp_rdata then equals the value on mem_dq_in during that last access cycle.
- R5: After the access, mem_oe_n and mem_ce_n are 1 for RD_REL_CYC cycles, the first of which carries the rsp_valid pulse, before req_ready returns.
- R6: mem_oe_n is 1 in every cycle in which mem_we_n is 0.
- R7: mem_addr is stable for the whole time mem_ce_n is 0, and a write presents it one cycle before mem_we_n falls.
- R8: mem_we_n is 0 for WR_REL_CYC + WR_DATA_CYC cycles. mem_dq_oe stays 0 for the first WR_REL_CYC of those cycles and is 1 for the last WR_DATA_CYC.
- R9: mem_dq_oe stays 1 for exactly one cycle after mem_we_n rises and is then 0. It is never 1 while mem_oe_n is 0 or while the memory may still drive the bus.
- R10: Each period with mem_ce_n at 0 carries exactly one access. mem_oe_n only falls after a cycle with mem_dq_oe at 0.
- R11: A write keeps req_ready low for WR_REL_CYC + WR_DATA_CYC + 2 cycles after acceptance. A read keeps it low for RD_ACC_CYC + RD_REL_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read byte |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq_out | output | DATA_W | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus when 1 |
| mem_dq_in | input | DATA_W | Byte seen on the data bus |

## Verification
The assertions take for granted three things: every timing parameter is at least one, the memory puts valid data on mem_dq_in no later than the last access cycle, and it releases the bus within RD_REL_CYC cycles after output enable rises. The bench's memory model keeps to exactly these limits. It returns a junk byte until the access count is reached, and it counts itself as driving for one cycle after a read ends. That model also checks every write against the pulse, data setup and contention limits. The host stimulus raises req_valid only in a cycle where req_ready is already high, and never changes a request once it has been raised.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_RELEASE,
        ST_WR_ADDR,
        ST_WR_GAP,
        ST_WR_DRIVE,
        ST_WR_HOLD
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
        logic ready;
    } pin_ctl_t;

    localparam pin_ctl_t CTL_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                       dq_oe: 1'b0, ready: 1'b0};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int RD_ACC_CYC  = 2,
    parameter int RD_REL_CYC  = 1,
    parameter int WR_REL_CYC  = 1,
    parameter int WR_DATA_CYC = 1,
    parameter int CNT_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_fire,
    input  logic             req_write,
    input  logic             tmr_expired,
    output pin_ctl_t         ctl,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             cap_en
);

    localparam logic [CNT_W-1:0] LD_RD_ACC  = CNT_W'(RD_ACC_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RD_REL  = CNT_W'(RD_REL_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WR_REL  = CNT_W'(WR_REL_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WR_DATA = CNT_W'(WR_DATA_CYC - 1);

    seq_state_t state_q, state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_fire) state_nxt = req_write ? ST_WR_ADDR : ST_RD_ACCESS;
            ST_RD_ACCESS:  if (tmr_expired) state_nxt = ST_RD_RELEASE;
            ST_RD_RELEASE: if (tmr_expired) state_nxt = ST_IDLE;
            ST_WR_ADDR:    state_nxt = ST_WR_GAP;
            ST_WR_GAP:     if (tmr_expired) state_nxt = ST_WR_DRIVE;
            ST_WR_DRIVE:   if (tmr_expired) state_nxt = ST_WR_HOLD;
            ST_WR_HOLD:    state_nxt = ST_IDLE;
            default:       state_nxt = ST_IDLE;
        endcase
    end

    // interval timer reload on every state change
    always_comb begin
        tmr_load = (state_nxt != state_q);
        unique case (state_nxt)
            ST_RD_ACCESS:  tmr_val = LD_RD_ACC;
            ST_RD_RELEASE: tmr_val = LD_RD_REL;
            ST_WR_GAP:     tmr_val = LD_WR_REL;
            ST_WR_DRIVE:   tmr_val = LD_WR_DATA;
            default:       tmr_val = '0;
        endcase
    end

    // pin controls, decoded from the state
    always_comb begin
        ctl    = CTL_QUIET;
        cap_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ctl.ready = 1'b1;
            end
            ST_RD_ACCESS: begin
                ctl.ce_n = 1'b0;
                ctl.oe_n = 1'b0;
                cap_en   = tmr_expired;
            end
            ST_RD_RELEASE: begin
            end
            ST_WR_ADDR: begin
                ctl.ce_n = 1'b0;
            end
            ST_WR_GAP: begin
                ctl.ce_n = 1'b0;
                ctl.we_n = 1'b0;
            end
            ST_WR_DRIVE: begin
                ctl.ce_n  = 1'b0;
                ctl.we_n  = 1'b0;
                ctl.dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                ctl.ce_n  = 1'b0;
                ctl.dq_oe = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cap_en;
            if (cap_en) begin
                rsp_rdata <= dq_in;
            end
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int RD_ACC_CYC  = 2,
    parameter int RD_REL_CYC  = 1,
    parameter int WR_REL_CYC  = 1,
    parameter int WR_DATA_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned T_MAX = max2(max2(RD_ACC_CYC, RD_REL_CYC),
                                         max2(WR_REL_CYC, WR_DATA_CYC));
    localparam int CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);

    pin_ctl_t          ctl;
    logic              req_fire;
    logic              tmr_load;
    logic              tmr_expired;
    logic [CNT_W-1:0]  tmr_val;
    logic              cap_en;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign req_fire = req_valid && ctl.ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (req_fire) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    asram_fsm #(
        .RD_ACC_CYC (RD_ACC_CYC),
        .RD_REL_CYC (RD_REL_CYC),
        .WR_REL_CYC (WR_REL_CYC),
        .WR_DATA_CYC(WR_DATA_CYC),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_fire   (req_fire),
        .req_write  (req_write),
        .tmr_expired(tmr_expired),
        .ctl        (ctl),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .cap_en     (cap_en)
    );

    asram_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    asram_rdcap #(
        .DATA_W(DATA_W)
    ) u_rdcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .dq_in    (mem_dq_in),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    assign req_ready  = ctl.ready;
    assign mem_ce_n   = ctl.ce_n;
    assign mem_we_n   = ctl.we_n;
    assign mem_oe_n   = ctl.oe_n;
    assign mem_dq_oe  = ctl.dq_oe;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W     = 17,
    parameter int RD_ACC_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);

    logic        rd_act;
    logic        rd_act_q;
    logic [15:0] rd_run;

    assign rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
            rd_run   <= '0;
        end else begin
            rd_act_q <= rd_act;
            rd_run   <= rd_act ? rd_run + 16'd1 : 16'd0;
        end
    end

    p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_read_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act_q && !rd_act) |-> (rd_run == 16'(RD_ACC_CYC)));

    p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_oe_n && mem_ce_n && !req_ready));

    p_oe_high_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    p_drv_after_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe);

    p_hold_after_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));

    p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_turnaround_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .RD_ACC_CYC(RD_ACC_CYC)
) u_chk (.*);

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
module asram_ctrl_test;

    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int RACC  = 3;
    localparam int RREL  = 2;
    localparam int WREL  = 2;
    localparam int WDAT  = 2;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    always #4 clk = ~clk;

    asram_ctrl #(
        .ADDR_W(AW), .DATA_W(DW),
        .RD_ACC_CYC(RACC), .RD_REL_CYC(RREL),
        .WR_REL_CYC(WREL), .WR_DATA_CYC(WDAT)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // ---------------- behavioural memory model ----------------
    logic [DW-1:0] mmem [WORDS];
    logic [DW-1:0] sb   [WORDS];
    int            rd_cnt = 0;
    logic          mtail = 1'b0;
    logic          rd_act;

    assign rd_act    = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq_in = (rd_act && rd_cnt >= RACC - 1) ? mmem[mem_addr] : 8'h5A;

    always @(posedge clk) begin
        rd_cnt <= rd_act ? rd_cnt + 1 : 0;
        mtail  <= rd_act;
    end

    logic          prev_we = 1'b1;
    logic          prev_ce = 1'b1;
    logic [AW-1:0] win_addr = '0;
    int            we_lo = 0;
    int            drv_lo = 0;
    bit            wr_in_win = 0;
    bit            rd_in_win = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n && prev_ce) win_addr = mem_addr;
            if (mem_dq_oe && (rd_act || mtail))
                chk(0, "R9 controller drives while memory drives", 1, 0);
            if (!mem_we_n && !mem_oe_n)
                chk(0, "R6 output enable low during write strobe", 0, 1);
            if (!mem_we_n) begin
                we_lo++;
                if (mem_dq_oe) drv_lo++;
            end
            if (rd_act) rd_in_win = 1;
            if (prev_we == 1'b0 && mem_we_n) begin
                chk(we_lo >= WREL + WDAT, "R8 write pulse width", we_lo, WREL + WDAT);
                chk(drv_lo >= WDAT, "R8 data setup before strobe rise", drv_lo, WDAT);
                chk(mem_dq_oe == 1'b1, "R9 data hold after strobe rise", mem_dq_oe, 1);
                chk(mem_addr == win_addr, "R7 address stable in write", mem_addr, win_addr);
                mmem[mem_addr] = mem_dq_out;
                wr_in_win = 1;
                we_lo = 0;
                drv_lo = 0;
            end
            if (mem_ce_n && !prev_ce) begin
                chk(!(wr_in_win && rd_in_win), "R10 one access per select window",
                    int'(wr_in_win) + int'(rd_in_win), 1);
                wr_in_win = 0;
                rd_in_win = 0;
            end
            prev_we = mem_we_n;
            prev_ce = mem_ce_n;
        end
    end

    // ---------------- host tasks ----------------
    function automatic logic [DW-1:0] pat(input int a, input int pass);
        return DW'((a * 29 + 7 + pass * 113) ^ (a >> 2));
    endfunction

    task automatic do_write(input int a, input logic [DW-1:0] d);
        int n = 0, wl = 0, dr = 0, oel = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = AW'(a); req_wdata = d;
        @(posedge clk);
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            n++;
            if (!mem_we_n) wl++;
            if (mem_dq_oe) dr++;
            if (!mem_oe_n) oel++;
        end while (!req_ready && n < 100);
        chk(n == WREL + WDAT + 3, "R2 R11 write busy length", n - 1, WREL + WDAT + 2);
        chk(wl == WREL + WDAT, "R8 strobe low cycles", wl, WREL + WDAT);
        chk(dr == WDAT + 1, "R9 driver on cycles", dr, WDAT + 1);
        chk(oel == 0, "R6 output enable during write", oel, 0);
        sb[a] = d;
    endtask

    task automatic do_read(input int a);
        int n = 0, oel = 0, nrsp = 0, rcnt = 0, rel_bad = 0;
        logic [DW-1:0] got = '0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        @(posedge clk);
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            n++;
            if (!mem_oe_n) oel++;
            if (rsp_valid) begin
                rcnt++;
                nrsp = n;
                got = rsp_rdata;
                if (!mem_oe_n || !mem_ce_n) rel_bad++;
            end
        end while (!req_ready && n < 100);
        chk(oel == RACC, "R3 output enable low cycles", oel, RACC);
        chk(nrsp == RACC + 1, "R4 response cycle", nrsp, RACC + 1);
        chk(rcnt == 1, "R4 response pulse count", rcnt, 1);
        chk(got == sb[a], "R4 read data", got, sb[a]);
        chk(rel_bad == 0, "R5 strobes high at response", rel_bad, 0);
        chk(n == RACC + RREL + 1, "R5 R11 read busy length", n - 1, RACC + RREL);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mmem[i] = 8'h00;
            sb[i]   = 8'h00;
        end
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high in reset",
            {mem_ce_n, mem_we_n, mem_oe_n}, 7);
        chk(!mem_dq_oe && req_ready && !rsp_valid, "R1 bus off and ready in reset",
            {mem_dq_oe, req_ready, rsp_valid}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid,
            "R1 idle after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 29);

        for (int a = 0; a < WORDS; a++) do_write(a, pat(a, 0));
        for (int a = 0; a < WORDS; a++) do_read(a);
        for (int a = 0; a < WORDS; a += 2) do_write(a, ~pat(a, 1));
        for (int a = WORDS - 1; a >= 0; a--) do_read(a);

        do_write(5, 8'h00);
        do_read(5);
        do_write(5, 8'hFF);
        do_read(5);
        do_read(6);
        do_write(6, 8'hC3);
        do_read(6);
        do_write(WORDS - 1, 8'h3C);
        do_write(0, 8'h81);
        do_read(WORDS - 1);
        do_read(0);

        repeat (4) @(negedge clk);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        summary();
    end

endmodule